// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block carries 32-bit messages from one processor to another through a small first-in, first-out queue. Each processor has its own word-addressed register port. The sending side writes a word to its send register. The receiving side reads the word back from its receive register, and that read also removes the word from the queue. Both ports read the same status word, which reports whether the queue is full or empty and holds two sticky error flags. Both ports also share one control register. That register enables an interrupt to the receiver and clears the error flags.

Each message word has two fields. The low four bits name a logical channel and the upper twenty-eight bits are the payload. The block does not interpret either field. The package provides helper functions that build a word from a channel and a payload and split a word back into the two fields.

Top module: `ipc_mailbox`

## Requirements
- R1: A message word keeps its channel in bits [3:0] and its payload in bits [31:4]. It leaves the receive register exactly as it was written.
- R2: The queue holds DEPTH (default 8) words and returns them in the order they were written.
- R3: Status bit 31 reads 1 exactly when the queue holds DEPTH words.
- R4: Status bit 30 reads 1 exactly when the queue holds no word.
- R5: A receive-port read of word address 0 (byte 0x00) returns the oldest word in that same access, and the word is removed at the clock edge that ends the access.
- R6: A send-port write to word address 8 (byte 0x20) while the queue is full is discarded, and sticky status bit 0 (overflow) is set.
- R7: A receive-port read of word address 0 while the queue is empty returns 0, and sticky status bit 1 (underflow) is set.
- R8: Control bit 0 enables the interrupt output, which is high exactly while the bit is set and the queue is not empty.
- R9: Writing the control register (word address 7, byte 0x1C) with bit 1 set clears both sticky bits. Bit 1 always reads back as 0.
- R10: Word addresses 1 to 5 and 9 to 15 read 0 and ignore writes. A send-port read of address 0 returns 0 and removes nothing. A receive-port write to address 8 adds nothing.
- R11: Reset empties the queue and clears the control register and both sticky bits.
- R12: The status word (word address 6, byte 0x18) and the control register read the same from both ports, and either port may write the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_sel | input | 1 | Send-port access strobe |
| tx_wr | input | 1 | Send-port write (1) or read (0) |
| tx_addr | input | 4 | Send-port word address |
| tx_wdata | input | 32 | Send-port write data |
| tx_rdata | output | 32 | Send-port read data, valid in the access cycle |
| rx_sel | input | 1 | Receive-port access strobe |
| rx_wr | input | 1 | Receive-port write (1) or read (0) |
| rx_addr | input | 4 | Receive-port word address |
| rx_wdata | input | 32 | Receive-port write data |
| rx_rdata | output | 32 | Receive-port read data, valid in the access cycle |
| irq | output | 1 | Interrupt request toward the receiver |

## Verification
The bench builds the block with its default depth of 8. At that depth it can fill the queue completely, push one more word to trigger a dropped write, and then drain past empty to trigger an underflow, all within a few dozen accesses. Each drained word has a distinct channel and payload, so any reordering or field corruption shows up in the data. The small depth also lets the bench check the interrupt as it rises on the first stored word and falls on the last removed word.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

  localparam int MSG_W   = 32;
  localparam int CHAN_W  = 4;
  localparam int WADDR_W = 4;

  // word offsets of the register map (byte offset / 4)
  localparam logic [WADDR_W-1:0] OFS_RECV = 4'd0;
  localparam logic [WADDR_W-1:0] OFS_STAT = 4'd6;
  localparam logic [WADDR_W-1:0] OFS_CTRL = 4'd7;
  localparam logic [WADDR_W-1:0] OFS_SEND = 4'd8;

  // bit positions
  localparam int ST_FULL_BIT  = 31;
  localparam int ST_EMPTY_BIT = 30;
  localparam int ST_UNF_BIT   = 1;
  localparam int ST_OVF_BIT   = 0;
  localparam int CFG_IRQ_BIT  = 0;
  localparam int CFG_CLR_BIT  = 1;

  localparam logic [MSG_W-1:0] CHAN_MASK = MSG_W'((1 << CHAN_W) - 1);

  // combine a channel number with a data word whose low bits are discarded
  function automatic logic [MSG_W-1:0] msg_pack(input logic [CHAN_W-1:0] chan,
                                                input logic [MSG_W-1:0]  data);
    return (data & ~CHAN_MASK) | (MSG_W'(chan) & CHAN_MASK);
  endfunction

  function automatic logic [CHAN_W-1:0] msg_chan(input logic [MSG_W-1:0] word);
    return word[CHAN_W-1:0];
  endfunction

  function automatic logic [MSG_W-1:0] msg_payload(input logic [MSG_W-1:0] word);
    return word & ~CHAN_MASK;
  endfunction

  // assemble the shared status word
  function automatic logic [MSG_W-1:0] status_word(input logic full, input logic empty,
                                                   input logic unf, input logic ovf);
    logic [MSG_W-1:0] s;
    s = '0;
    s[ST_FULL_BIT]  = full;
    s[ST_EMPTY_BIT] = empty;
    s[ST_UNF_BIT]   = unf;
    s[ST_OVF_BIT]   = ovf;
    return s;
  endfunction

  function automatic logic [MSG_W-1:0] ctrl_word(input logic irq_en);
    logic [MSG_W-1:0] c;
    c = '0;
    c[CFG_IRQ_BIT] = irq_en;
    return c;
  endfunction

  // fill level from pointers carrying one wrap bit
  function automatic int unsigned ptr_level(input int unsigned wptr, input int unsigned rptr,
                                            input int unsigned ptr_bits);
    return (wptr - rptr) & ((1 << ptr_bits) - 1);
  endfunction

endpackage

// File: rtl/ipc_mbx_queue.sv
module ipc_mbx_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty,
  output logic         push_ok,
  output logic         pop_ok,
  output logic         push_drop,
  output logic         pop_under
);
  import ipc_mbx_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [LVL_W-1:0] wptr, rptr;
  logic [LVL_W-1:0] level;

  assign level = LVL_W'(ptr_level(32'(wptr), 32'(rptr), LVL_W));
  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);

  // acceptance is judged on the state before the edge
  assign push_ok   = push & ~full;
  assign pop_ok    = pop & ~empty;
  assign push_drop = push & full;
  assign pop_under = pop & empty;

  assign head = mem[rptr[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr[PTR_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
    end
  end

  // R2
  level_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (32'(level) == 32'($past(level)) + 1));

  // R5
  level_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> (32'(level) + 1 == 32'($past(level))));

  // R6
  drop_keeps_wptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> (wptr == $past(wptr)));

endmodule

// File: rtl/ipc_mbx_ctrl.sv
module ipc_mbx_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_cfg_wr,
  input  logic [1:0] tx_cfg_bits,
  input  logic       rx_cfg_wr,
  input  logic [1:0] rx_cfg_bits,
  input  logic       push_drop,
  input  logic       pop_under,
  input  logic       empty,
  output logic       irq_en,
  output logic       ovf,
  output logic       unf,
  output logic       irq
);
  import ipc_mbx_pkg::*;

  logic       cfg_wr;
  logic [1:0] cfg_bits;
  logic       err_clr;

  // receive port takes priority on a same-cycle collision
  assign cfg_wr   = tx_cfg_wr | rx_cfg_wr;
  assign cfg_bits = rx_cfg_wr ? rx_cfg_bits : tx_cfg_bits;
  assign err_clr  = cfg_wr & cfg_bits[CFG_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (cfg_wr) irq_en <= cfg_bits[CFG_IRQ_BIT];
      // a new event wins over a clear in the same cycle
      ovf <= push_drop | (ovf & ~err_clr);
      unf <= pop_under | (unf & ~err_clr);
    end
  end

  assign irq = irq_en & ~empty;

  // R6
  ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf);

  // R7
  unf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_under |=> unf);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !push_drop && !pop_under) |=> (!ovf && !unf));

endmodule

// File: rtl/ipc_mbx_port.sv
module ipc_mbx_port #(
  parameter bit CAN_SEND = 1'b1,
  parameter int ADDR_W   = 4,
  parameter int W        = 32
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      status,
  input  logic [W-1:0]      ctrl,
  input  logic [W-1:0]      head,
  input  logic              empty,
  output logic [W-1:0]      rdata,
  output logic              push,
  output logic              pop,
  output logic              cfg_wr
);
  import ipc_mbx_pkg::*;

  logic rd_hit;
  logic wr_hit;
  logic [W-1:0] recv_view;

  assign rd_hit = sel & ~wr;
  assign wr_hit = sel & wr;
  assign cfg_wr = wr_hit & (addr == ADDR_W'(OFS_CTRL));

  generate
    if (CAN_SEND) begin : g_send
      assign push      = wr_hit & (addr == ADDR_W'(OFS_SEND));
      assign pop       = 1'b0;
      assign recv_view = '0;
    end else begin : g_recv
      assign push      = 1'b0;
      assign pop       = rd_hit & (addr == ADDR_W'(OFS_RECV));
      assign recv_view = empty ? '0 : head;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (addr)
        ADDR_W'(OFS_RECV): rdata = recv_view;
        ADDR_W'(OFS_STAT): rdata = status;
        ADDR_W'(OFS_CTRL): rdata = ctrl;
        default:           rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = ipc_mbx_pkg::WADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tx_sel,
  input  logic                         tx_wr,
  input  logic [ADDR_W-1:0]            tx_addr,
  input  logic [ipc_mbx_pkg::MSG_W-1:0] tx_wdata,
  output logic [ipc_mbx_pkg::MSG_W-1:0] tx_rdata,
  input  logic                         rx_sel,
  input  logic                         rx_wr,
  input  logic [ADDR_W-1:0]            rx_addr,
  input  logic [ipc_mbx_pkg::MSG_W-1:0] rx_wdata,
  output logic [ipc_mbx_pkg::MSG_W-1:0] rx_rdata,
  output logic                         irq
);
  import ipc_mbx_pkg::*;

  localparam int W = MSG_W;

  // named internal events
  logic         q_push, q_pop, q_full, q_empty;
  logic         q_push_ok, q_pop_ok, q_push_drop, q_pop_under;
  logic [W-1:0] q_head;
  logic         tx_push, tx_pop, tx_cfg_wr;
  logic         rx_push, rx_pop, rx_cfg_wr;
  logic         irq_en, ovf, unf;
  logic [W-1:0] status, ctrl;

  assign q_push = tx_push | rx_push;
  assign q_pop  = tx_pop | rx_pop;
  assign status = status_word(q_full, q_empty, unf, ovf);
  assign ctrl   = ctrl_word(irq_en);

  ipc_mbx_port #(.CAN_SEND(1'b1), .ADDR_W(ADDR_W), .W(W)) u_tx_port (
    .sel(tx_sel), .wr(tx_wr), .addr(tx_addr),
    .status(status), .ctrl(ctrl), .head(q_head), .empty(q_empty),
    .rdata(tx_rdata), .push(tx_push), .pop(tx_pop), .cfg_wr(tx_cfg_wr)
  );

  ipc_mbx_port #(.CAN_SEND(1'b0), .ADDR_W(ADDR_W), .W(W)) u_rx_port (
    .sel(rx_sel), .wr(rx_wr), .addr(rx_addr),
    .status(status), .ctrl(ctrl), .head(q_head), .empty(q_empty),
    .rdata(rx_rdata), .push(rx_push), .pop(rx_pop), .cfg_wr(rx_cfg_wr)
  );

  ipc_mbx_queue #(.DEPTH(DEPTH), .W(W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_data(tx_wdata), .pop(q_pop),
    .head(q_head), .full(q_full), .empty(q_empty),
    .push_ok(q_push_ok), .pop_ok(q_pop_ok),
    .push_drop(q_push_drop), .pop_under(q_pop_under)
  );

  ipc_mbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .tx_cfg_wr(tx_cfg_wr), .tx_cfg_bits(tx_wdata[1:0]),
    .rx_cfg_wr(rx_cfg_wr), .rx_cfg_bits(rx_wdata[1:0]),
    .push_drop(q_push_drop), .pop_under(q_pop_under), .empty(q_empty),
    .irq_en(irq_en), .ovf(ovf), .unf(unf), .irq(irq)
  );

  // R10
  rx_never_pushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel && rx_wr && !tx_sel) |=> ($past(q_empty) -> q_empty));

  // R11
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |-> (q_empty && !irq));

endmodule

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_sel = 0, tx_wr = 0, rx_sel = 0, rx_wr = 0;
  logic [3:0]  tx_addr = 0, rx_addr = 0;
  logic [31:0] tx_wdata = 0, rx_wdata = 0;
  logic [31:0] tx_rdata, rx_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_sel(tx_sel), .tx_wr(tx_wr), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .tx_rdata(tx_rdata),
    .rx_sel(rx_sel), .rx_wr(rx_wr), .rx_addr(rx_addr), .rx_wdata(rx_wdata), .rx_rdata(rx_rdata),
    .irq(irq)
  );

  localparam logic [31:0] ST_EMPTY = 32'h4000_0000;
  localparam logic [31:0] ST_FULL  = 32'h8000_0000;

  // port: 0 send side, 1 receive side
  typedef struct packed {
    logic        port;
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        chk;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 4'd6, 32'h0,         ST_EMPTY,         1'b1, 8'd11}, // R11 status after reset
    '{1'b0, 1'b0, 4'd7, 32'h0,         32'h0,            1'b1, 8'd11}, // R11 control after reset
    '{1'b0, 1'b1, 4'd8, 32'h1234_5673, 32'h0,            1'b0, 8'd2},
    '{1'b0, 1'b1, 4'd8, 32'hABCD_EF08, 32'h0,            1'b0, 8'd2},
    '{1'b0, 1'b0, 4'd6, 32'h0,         32'h0,            1'b1, 8'd4},  // R4 neither flag
    '{1'b1, 1'b0, 4'd0, 32'h0,         32'h1234_5673,    1'b1, 8'd5},  // R5 oldest first
    '{1'b1, 1'b0, 4'd0, 32'h0,         32'hABCD_EF08,    1'b1, 8'd5},
    '{1'b1, 1'b0, 4'd6, 32'h0,         ST_EMPTY,         1'b1, 8'd4},  // R4 empty again
    '{1'b1, 1'b0, 4'd0, 32'h0,         32'h0,            1'b1, 8'd7},  // R7 empty read
    '{1'b0, 1'b0, 4'd6, 32'h0,         ST_EMPTY | 32'h2, 1'b1, 8'd7},  // R7 sticky
    '{1'b0, 1'b1, 4'd7, 32'h2,         32'h0,            1'b0, 8'd9},
    '{1'b1, 1'b0, 4'd6, 32'h0,         ST_EMPTY,         1'b1, 8'd9},  // R9 cleared
    '{1'b0, 1'b1, 4'd3, 32'hFFFF_FFFF, 32'h0,            1'b0, 8'd10},
    '{1'b0, 1'b0, 4'd3, 32'h0,         32'h0,            1'b1, 8'd10}, // R10 reserved
    '{1'b0, 1'b0, 4'd0, 32'h0,         32'h0,            1'b1, 8'd10}, // R10 send port read 0
    '{1'b0, 1'b0, 4'd6, 32'h0,         ST_EMPTY,         1'b1, 8'd10}  // R10 no underflow
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic port, input logic wr, input logic [3:0] a,
                     input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    if (port) begin
      rx_sel = 1; rx_wr = wr; rx_addr = a; rx_wdata = d;
    end else begin
      tx_sel = 1; tx_wr = wr; tx_addr = a; tx_wdata = d;
    end
    #2;
    rd = port ? rx_rdata : tx_rdata;
    @(posedge clk);
    #1;
    tx_sel = 0; tx_wr = 0; rx_sel = 0; rx_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    tx_sel = 0; rx_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [31:0] make_word(input int i);
    logic [27:0] pay;
    pay = 28'(i * 32'h0111_1111 + 5);
    return {pay, 4'(15 - i)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    do_reset();
    check(11, {31'b0, irq}, 32'h0, "irq after reset"); // R11

    for (int v = 0; v < NV; v++) begin
      bus(VEC[v].port, VEC[v].wr, VEC[v].addr, VEC[v].wdata, rd);
      if (VEC[v].chk) check(int'(VEC[v].req), rd, VEC[v].exp, $sformatf("vector %0d", v));
    end

    // R10 receive port cannot push
    bus(1, 1, 4'd8, 32'h5555_5555, rd);
    bus(1, 0, 4'd6, 0, rd);
    check(10, rd, ST_EMPTY, "rx write to send reg");

    // R2 R3 fill to depth
    for (int i = 0; i < 8; i++) begin
      bus(0, 1, 4'd8, make_word(i), rd);
      if (i == 0) check(8, {31'b0, irq}, 32'h0, "irq masked while disabled");
    end
    bus(0, 0, 4'd6, 0, rd);
    check(3, rd, ST_FULL, "full after depth writes");
    bus(1, 0, 4'd6, 0, rd);
    check(12, rd, ST_FULL, "rx sees same status");

    // R6 extra write dropped
    bus(0, 1, 4'd8, 32'hDEAD_BEEF, rd);
    bus(0, 0, 4'd6, 0, rd);
    check(6, rd, ST_FULL | 32'h1, "overflow sticky");

    // R8 R12 enable irq from rx, read from tx
    bus(1, 1, 4'd7, 32'h1, rd);
    check(8, {31'b0, irq}, 32'h1, "irq with data and enable");
    bus(0, 0, 4'd7, 0, rd);
    check(12, rd, 32'h1, "control shared");

    // R1 R2 R5 drain in order
    for (int i = 0; i < 8; i++) begin
      bus(1, 0, 4'd0, 0, rd);
      check(2, rd, make_word(i), $sformatf("order slot %0d", i));
      check(1, {28'b0, rd[3:0]}, 32'(15 - i), "channel field");
      check(1, {rd[31:4], 4'b0}, {make_word(i)[31:4], 4'b0}, "payload field");
      if (i == 0) begin
        bus(1, 0, 4'd6, 0, rd);
        check(3, rd, 32'h1, "not full after one pop");
      end
    end
    check(8, {31'b0, irq}, 32'h0, "irq drops when empty");

    // R6 dropped word never appears
    bus(1, 0, 4'd0, 0, rd);
    check(6, rd, 32'h0, "dropped word absent");
    bus(1, 0, 4'd6, 0, rd);
    check(7, rd, ST_EMPTY | 32'h3, "both sticky bits");

    // R9 clear keeps enable, bit1 reads 0
    bus(1, 1, 4'd7, 32'h3, rd);
    bus(0, 0, 4'd6, 0, rd);
    check(9, rd, ST_EMPTY, "sticky cleared");
    bus(1, 0, 4'd7, 0, rd);
    check(9, rd, 32'h1, "clear bit reads 0");

    // R11 reset mid-activity
    bus(0, 1, 4'd8, 32'h0000_00F1, rd);
    check(8, {31'b0, irq}, 32'h1, "irq on first word");
    do_reset();
    bus(1, 0, 4'd6, 0, rd);
    check(11, rd, ST_EMPTY, "queue emptied by reset");
    bus(0, 0, 4'd7, 0, rd);
    check(11, rd, 32'h0, "control cleared by reset");
    check(11, {31'b0, irq}, 32'h0, "irq low after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule